// File: doc/BRIEF.md
# Sampling-Window Timing Error Detector

This block is a cycle-accurate synchronous model of one error-detecting storage stage. A fast reference clock drives it. One data bit passes through a latch that is transparent only while the window input is high. That open interval is the resiliency window, and it must be long enough to cover the slowest critical path of the stage. A transition detector turns every change of the data bit into a pulse of fixed width. A sticky hold cell records the pulse if it overlaps the armed part of the open window. A sample strobe near the end of the window copies the cell onto a dual-rail result.

The hold cell does not arm until the window has been open for `COMP_CYC` reference cycles. This compensation stops a data change that lands just before the window opens from being reported. Each detector pulse lasts `PULSE_CYC` cycles. The result rails stay neutral (both low) until the strobe. After the strobe, exactly one rail is high. They return to neutral when the next window opens.

There is no data stream to carry. All pins are plain level or strobe signals, so the block has no handshake and applies no back-pressure.

In the statements below, "cycle 0" is the first reference cycle in which `win_open` is sampled high, and W is the number of cycles the window stays high. Offset e is the cycle in which `data_in` first takes a new value. The defaults are `PULSE_CYC`=3 and `COMP_CYC`=2, and the block requires `COMP_CYC` < `PULSE_CYC`.

Top module: `twd_detector`

## Requirements
- R1: While `win_open` is high, `data_out` takes the value `data_in` had in the same cycle, visible after that clock edge. While `win_open` is low, `data_out` holds. Reset sets `data_out` to 0.
- R2: A single rising change of `data_in` at offset e, where 0 <= e <= W-2, gives `rail_fault`=1 and `rail_clean`=0 after a strobe in cycle W-1.
- R3: A single falling change under the same conditions gives the same fault result as a rise.
- R4: A window with no change of `data_in` gives `rail_clean`=1 and `rail_fault`=0 after the strobe.
- R5: A change in the strobe cycle (e = W-1) or later is not reported in that window's result.
- R6: A change before the window opens is reported only when e >= COMP_CYC-PULSE_CYC+1. With the defaults, a change in the cycle just before opening (e=-1) or earlier gives the clean result.
- R7: After the clock edge that samples `win_open` high for the first time in a window, both rails are 0. They stay 0 until the strobe.
- R8: Rail encoding as {`rail_fault`,`rail_clean`}: 00 means neutral, 01 means clean and 10 means fault, and 11 never appears. A result holds until the next window opens. A `sample_stb` pulse while `win_open` is low is ignored.
- R9: The hold cell clears whenever `win_open` is low. A fault in one window does not carry into the next window.
- R10: A synchronous active-low `rst_n` sets both rails to 0 and clears the hold cell and the pulse state. Reset in the middle of a window drops a violation seen before the reset.
- R11: Several changes inside one window still give a single fault result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 1 | Data bit from the combinational path |
| win_open | input | 1 | Resiliency window; the latch is transparent while high |
| sample_stb | input | 1 | Strobe that copies the hold cell onto the rails; it takes effect only while the window is high |
| data_out | output | 1 | Latched data |
| rail_clean | output | 1 | High after a strobe if no violation was recorded |
| rail_fault | output | 1 | High after a strobe if a violation was recorded |

## Verification
The bench moves one data change across a whole range of offsets. The offsets run from several cycles before the window opens, through the armed part, up to the strobe cycle and beyond. This separates the compensation boundary at e=-1 versus e=0 from the sampling boundary at e=W-2 versus e=W-1. The change alternates between rising and falling, which shows that both edge polarities trigger the detector equally. Windows with no change, with several changes, and a fault window followed by a quiet one tell a sticky cell apart from one that leaks between windows. Reset in the middle of a window and a strobe while the window is closed check that stale results are cleared and that a strobe outside the window has no effect.

// File: rtl/twd_pkg.sv
package twd_pkg;
  // Rail pair as {fault, clean}
  typedef enum logic [1:0] {
    RAIL_NEUTRAL = 2'b00,
    RAIL_CLEAN   = 2'b01,
    RAIL_FAULT   = 2'b10
  } rails_t;
endpackage

// File: rtl/twd_latch.sv
module twd_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic win_open,
  input  logic data_in,
  output logic data_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)        data_out <= 1'b0;
    else if (win_open) data_out <= data_in;
  end

  p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> (data_out == $past(data_in)));
  p_opaque_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(data_out));
endmodule

// File: rtl/twd_transdet.sv
module twd_transdet #(
  parameter int PULSE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic td_x
);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  logic prev_d;
  logic chg;

  // Previous value tracks the input even in reset, so release makes no false edge
  always_ff @(posedge clk) prev_d <= data_in;
  assign chg = data_in ^ prev_d;

  generate
    if (PULSE_CYC > 1) begin : g_stretch
      logic [PW-1:0] rem;
      always_ff @(posedge clk) begin
        if (!rst_n)          rem <= '0;
        else if (chg)        rem <= PW'(PULSE_CYC - 1);
        else if (rem != '0)  rem <= rem - 1'b1;
      end
      assign td_x = chg | (rem != '0);
    end else begin : g_single
      assign td_x = chg;
    end
  endgenerate

  p_edge_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_in != $past(data_in)) |-> td_x);
endmodule

// File: rtl/twd_hold_cell.sv
module twd_hold_cell #(
  parameter int COMP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_open,
  input  logic td_x,
  output logic hit
);
  localparam int CW = (COMP_CYC > 0) ? $clog2(COMP_CYC + 1) : 1;

  logic armed;

  generate
    if (COMP_CYC > 0) begin : g_comp
      logic [CW-1:0] open_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !win_open)              open_cnt <= '0;
        else if (open_cnt != CW'(COMP_CYC))   open_cnt <= open_cnt + 1'b1;
      end
      assign armed = win_open && (open_cnt == CW'(COMP_CYC));
    end else begin : g_nocomp
      assign armed = win_open;
    end
  endgenerate

  // Asymmetric set/reset: cleared while the window is low, set by an armed pulse
  always_ff @(posedge clk) begin
    if (!rst_n || !win_open)  hit <= 1'b0;
    else if (td_x && armed)   hit <= 1'b1;
  end

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> !hit);
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win_open) |=> hit);
  p_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> !hit);
endmodule

// File: rtl/twd_rail_out.sv
module twd_rail_out
  import twd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win_open,
  input  logic sample_stb,
  input  logic hit,
  output logic rail_clean,
  output logic rail_fault
);
  rails_t rails;
  logic   win_prev;
  logic   opening;

  always_ff @(posedge clk) win_prev <= win_open;
  assign opening = win_open && !win_prev;

  always_ff @(posedge clk) begin
    if (!rst_n || opening)         rails <= RAIL_NEUTRAL;
    else if (sample_stb && win_open) rails <= hit ? RAIL_FAULT : RAIL_CLEAN;
  end

  assign rail_fault = rails[1];
  assign rail_clean = rails[0];

  p_never_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rail_fault, rail_clean}));
  p_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && win_open && !$rose(win_open)) |=>
      (rail_fault == $past(hit)) && (rail_clean == !$past(hit)));
  p_neutral_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |=> (!rail_fault && !rail_clean));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sample_stb && win_open) && !$rose(win_open)) |=> $stable({rail_fault, rail_clean}));
endmodule

// File: rtl/twd_detector.sv
module twd_detector #(
  parameter int PULSE_CYC = 3,
  parameter int COMP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  input  logic win_open,
  input  logic sample_stb,
  output logic data_out,
  output logic rail_clean,
  output logic rail_fault
);
  logic td_x;
  logic hit;

  initial begin
    p_param_r6: assert (PULSE_CYC >= 1 && COMP_CYC >= 0 && COMP_CYC < PULSE_CYC);
  end

  twd_latch u_latch (
    .clk(clk), .rst_n(rst_n), .win_open(win_open),
    .data_in(data_in), .data_out(data_out)
  );

  twd_transdet #(.PULSE_CYC(PULSE_CYC)) u_td (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .td_x(td_x)
  );

  twd_hold_cell #(.COMP_CYC(COMP_CYC)) u_cell (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .td_x(td_x), .hit(hit)
  );

  twd_rail_out u_rails (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .sample_stb(sample_stb),
    .hit(hit), .rail_clean(rail_clean), .rail_fault(rail_fault)
  );
endmodule

// File: tb/twd_detector_tb.sv
module twd_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {offset of data change (99 = none), window length, expect fault}
  localparam int VEC [NVEC][3] = '{
    '{0, 6, 1}, '{2, 6, 1}, '{4, 6, 1}, '{5, 6, 0}, '{-1, 6, 0},
    '{-3, 6, 0}, '{99, 6, 0}, '{1, 4, 1}, '{2, 4, 1}, '{3, 4, 0},
    '{-1, 4, 0}, '{0, 4, 1}, '{3, 8, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0;
  logic win_open = 1'b0;
  logic sample_stb = 1'b0;
  logic data_out, rail_clean, rail_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic held = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twd_detector u_dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .win_open(win_open),
    .sample_stb(sample_stb), .data_out(data_out),
    .rail_clean(rail_clean), .rail_fault(rail_fault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic s, input logic d);
    win_open = w; sample_stb = s; data_in = d;
    @(posedge clk); #1;
  endtask

  task automatic chk_rails(input int exp_fault, input string req);
    int act;
    int exp;
    act = {rail_fault, rail_clean};
    exp = exp_fault ? 2 : 1;
    chk(act == exp, req, act, exp);
  endtask

  task automatic run_vec(input int e, input int w, input int exp_fault);
    string tag;
    int res;
    for (int c = -4; c <= w + 1; c++) begin
      bit wv;
      logic d;
      d = data_in;
      wv = (c >= 0 && c < w);
      if (c == e) d = ~d;
      step(wv, (c == w - 1), d);
      if (wv) held = d;
      chk(data_out == held, "R1", data_out, held);
      if (c == 0) chk({rail_fault, rail_clean} == 2'b00, "R7", {rail_fault, rail_clean}, 0);
      if (c == w - 1) begin
        if (e == 99) tag = "R4";
        else if (e < 0) tag = "R6";
        else if (e >= w - 1) tag = "R5";
        else tag = (data_in == 1'b1) ? "R2" : "R3";
        chk_rails(exp_fault, tag);
        res = {rail_fault, rail_clean};
      end
      if (c == w + 1) chk({rail_fault, rail_clean} == res, "R8", {rail_fault, rail_clean}, res);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state, data toggling during reset
    rst_n = 1'b0;
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk({rail_fault, rail_clean} == 2'b00, "R10", {rail_fault, rail_clean}, 0);
    chk(data_out == 1'b0, "R10", data_out, 0);
    rst_n = 1'b1;
    held = 1'b0;
    step(1'b0, 1'b0, data_in);

    // Table walk: R1..R8; order also gives fault window followed by clean (R9)
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R9: fault window then a quiet window
    run_vec(1, 6, 1);
    run_vec(99, 6, 0);
    chk(rail_clean == 1'b1, "R9", rail_clean, 1);

    // R11: several changes inside one window
    step(1'b0, 1'b0, data_in);
    for (int c = 0; c < 8; c++) begin
      logic d;
      d = data_in;
      if (c == 1 || c == 3 || c == 5) d = ~d;
      step(1'b1, (c == 7), d);
    end
    chk_rails(1, "R11");

    // R8: strobe with window closed is ignored
    step(1'b0, 1'b0, data_in);
    step(1'b0, 1'b1, data_in);
    step(1'b0, 1'b0, data_in);
    chk_rails(1, "R8");

    // R10: reset in the middle of a window drops the violation
    step(1'b0, 1'b0, data_in);
    step(1'b1, 1'b0, data_in);
    step(1'b1, 1'b0, ~data_in);
    step(1'b1, 1'b0, data_in);
    rst_n = 1'b0;
    step(1'b1, 1'b0, data_in);
    chk({rail_fault, rail_clean} == 2'b00, "R10", {rail_fault, rail_clean}, 0);
    chk(data_out == 1'b0, "R10", data_out, 0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, data_in);
    step(1'b1, 1'b0, data_in);
    step(1'b1, 1'b0, data_in);
    step(1'b1, 1'b1, data_in);
    chk_rails(0, "R10");
    step(1'b0, 1'b0, data_in);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule